// File: doc/BRIEF.md
# USB Host Controller Status and Interrupt Register

This block keeps the status word of a USB 2.0 host controller. Several parts of the controller report events to it as one-cycle pulses or as level signals: the asynchronous schedule engine, the memory read interface, the frame number counter and the root-hub ports. The block turns each event into a sticky flag. Software clears a flag by writing 1 to its bit. The block also reports whether the controller has really stopped running. That happens only after Run/Stop has dropped, the DMA engines have gone idle and no prefetch request is still outstanding.

A failed memory read sets the host-error flag. It also drives a one-cycle pulse that the command register uses to force Run/Stop low, so no further transfer descriptors run. The port logic presents four change bits for each port, together with an ownership flag. Only ports owned by this controller raise the port-change flag. The one exception is a connect change, which counts on every port. A wake pulse marks the return from the low-power device state. On a wake pulse, the port-change flag is loaded from the OR of all change bits that are currently high. The interrupt line is the registered OR of the sticky flags, each gated by the enable bit from the interrupt-enable register.

Top module: `usbh_stat_reg`

## Requirements
- R1: `status_o[12]` (halted) reads 0 in every cycle in which `run_cmd_i` is 1, including the first such cycle.
- R2: With `run_cmd_i` at 0, halted becomes 1 one clock after the first cycle in which `engines_idle_i` is 1 and `prefetch_pend_i` is 0. It stays 0 while either condition is missing.
- R3: A pulse on `adv_done_i` sets `status_o[5]` (async advance) one clock later.
- R4: A completion with `rd_done_i`=1 and `rd_resp_i` not equal to 2'b00 (2'b00 means success) sets `status_o[4]` (host error) one clock later. In that same cycle it gives a single-cycle pulse on `run_clear_o`. A successful completion does neither.
- R5: A change of `frame_num_i[13]` between consecutive cycles sets `status_o[3]` (frame rollover) one clock later. Changes of the other frame bits have no effect.
- R6: Port p occupies change bits `port_chg_i[4p+3:4p]`, laid out as bit 0 connect change, bit 1 enable change, bit 2 over-current change and bit 3 force resume. A 0-to-1 transition of any of these bits on a port with `port_owner_i[p]`=0 sets `status_o[2]` (port change) one clock later. On a port with `port_owner_i[p]`=1, only a rising connect change does so.
- R7: A pulse on `wake_i` sets `status_o[2]` one clock later if any bit of `port_chg_i` is 1 at that time. If all of them are 0, the pulse leaves `status_o[2]` unchanged.
- R8: With `wr_en_i`=1, a 1 in `wr_data_i` at bit 5, 4, 3 or 2 clears that flag one clock later. A 0 leaves the flag as it is. When a set event and a clearing write happen in the same cycle, the flag stays set.
- R9: `irq_o` is 1 exactly one clock after a cycle in which some flag `status_o[2+k]` and its enable `irq_en_i[k]` are both 1.
- R10: Bits 15:13, 11:6 and 1:0 of `status_o` always read 0.
- R11: While `rst` is high and just after it is released, `status_o` reads 16'h1000 when `run_cmd_i` is 0, and `irq_o` and `run_clear_o` are 0. Edge and toggle events in the first cycle after reset are not recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_cmd_i | input | 1 | Run/Stop command bit |
| engines_idle_i | input | 1 | All DMA engines idle |
| prefetch_pend_i | input | 1 | A prefetch request is outstanding |
| adv_done_i | input | 1 | Pulse: async schedule advanced after doorbell |
| rd_done_i | input | 1 | Pulse: memory read completion |
| rd_resp_i | input | 2 | Completion response, 2'b00 success |
| frame_num_i | input | FRAME_W | Frame number counter |
| port_chg_i | input | NPORT*4 | Per-port change bits |
| port_owner_i | input | NPORT | 1 = port handed to another controller |
| wake_i | input | 1 | Pulse: return from low-power device state |
| irq_en_i | input | 4 | Interrupt enables for status bits 5..2 |
| wr_en_i | input | 1 | Status write strobe |
| wr_data_i | input | 16 | Write-one-to-clear data |
| status_o | output | 16 | Status word |
| run_clear_o | output | 1 | Pulse forcing Run/Stop low |
| irq_o | output | 1 | Interrupt request |

## Verification
A flag register holding the wrong value shows up on `status_o` one clock after the event that should have changed it. It then shows up on `irq_o` one clock later when the flag's enable is set. A halt tracker in the wrong state either lets the halted bit rise while the engines are still busy or a prefetch is still pending, or fails to drop the bit in the cycle Run/Stop rises. An edge detector with stale history either misses a port or frame event, or invents one, and this is visible on the next cycle's status word.

// File: rtl/usbh_stat_pkg.sv
package usbh_stat_pkg;

    localparam int STAT_W   = 16;
    localparam int BIT_PCD  = 2;
    localparam int BIT_FLR  = 3;
    localparam int BIT_HSE  = 4;
    localparam int BIT_AAD  = 5;
    localparam int BIT_HLT  = 12;
    localparam int EVT_N    = 4;
    localparam int EVT_LSB  = BIT_PCD;
    localparam int ROLL_BIT = 13;

    // per-port change bit layout
    localparam int CHG_W    = 4;
    localparam int CHG_CONN = 0;
    localparam int CHG_ENA  = 1;
    localparam int CHG_OVC  = 2;
    localparam int CHG_RES  = 3;

    typedef logic [1:0] rd_resp_t;
    localparam rd_resp_t RESP_OK = 2'b00;

    // packed msb..lsb matches status bits 5..2
    typedef struct packed {
        logic aad;
        logic hse;
        logic flr;
        logic pcd;
    } evt_t;

    function automatic logic [STAT_W-1:0] pack_status(input evt_t flags,
                                                      input logic halted);
        logic [STAT_W-1:0] w;
        w = '0;
        w[BIT_AAD] = flags.aad;
        w[BIT_HSE] = flags.hse;
        w[BIT_FLR] = flags.flr;
        w[BIT_PCD] = flags.pcd;
        w[BIT_HLT] = halted;
        return w;
    endfunction

endpackage

// File: rtl/usbh_halt_trk.sv
module usbh_halt_trk (
    input  logic clk,
    input  logic rst,
    input  logic run_i,
    input  logic idle_i,
    input  logic pend_i,
    output logic halted_o
);
    logic halted_q;

    always_ff @(posedge clk) begin
        if (rst)
            halted_q <= 1'b1;
        else if (run_i)
            halted_q <= 1'b0;
        else if (idle_i && !pend_i)
            halted_q <= 1'b1;
    end

    // masked so the bit drops in the same cycle Run/Stop rises
    assign halted_o = halted_q & ~run_i;
endmodule

// File: rtl/usbh_edge_det.sv
module usbh_edge_det #(
    parameter int W      = 1,
    parameter bit TOGGLE = 1'b0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] lvl_i,
    output logic [W-1:0] evt_o
);
    logic [W-1:0] prev_q;
    logic         primed_q;
    logic [W-1:0] diff;

    always_ff @(posedge clk) begin
        prev_q <= lvl_i;
        if (rst)
            primed_q <= 1'b0;
        else
            primed_q <= 1'b1;
    end

    generate
        if (TOGGLE) begin : g_toggle
            assign diff = lvl_i ^ prev_q;
        end else begin : g_rise
            assign diff = lvl_i & ~prev_q;
        end
    endgenerate

    assign evt_o = primed_q ? diff : '0;
endmodule

// File: rtl/usbh_port_agg.sv
module usbh_port_agg
    import usbh_stat_pkg::*;
#(
    parameter int NPORT = 4
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NPORT*CHG_W-1:0] chg_i,
    input  logic [NPORT-1:0]       owner_i,
    input  logic                   wake_i,
    output logic                   pcd_set_o
);
    localparam int VEC_W = NPORT * CHG_W;

    logic [VEC_W-1:0] rise;
    logic [NPORT-1:0] port_hit;

    usbh_edge_det #(.W(VEC_W), .TOGGLE(1'b0)) chg_edge_i (
        .clk   (clk),
        .rst   (rst),
        .lvl_i (chg_i),
        .evt_o (rise)
    );

    generate
        for (genvar p = 0; p < NPORT; p++) begin : g_port
            // foreign-owned ports only report connect changes
            assign port_hit[p] = owner_i[p] ? rise[p*CHG_W + CHG_CONN]
                                            : |rise[p*CHG_W +: CHG_W];
        end
    endgenerate

    assign pcd_set_o = (|port_hit) | (wake_i & (|chg_i));
endmodule

// File: rtl/usbh_w1c_bank.sv
module usbh_w1c_bank #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] q_o
);
    generate
        for (genvar i = 0; i < N; i++) begin : g_bit
            logic q;
            always_ff @(posedge clk) begin
                if (rst)
                    q <= 1'b0;
                else if (set_i[i])
                    q <= 1'b1;
                else if (clr_i[i])
                    q <= 1'b0;
            end
            assign q_o[i] = q;
        end
    endgenerate
endmodule

// File: rtl/usbh_stat_reg.sv
module usbh_stat_reg
    import usbh_stat_pkg::*;
#(
    parameter int NPORT   = 4,
    parameter int FRAME_W = 14
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   run_cmd_i,
    input  logic                   engines_idle_i,
    input  logic                   prefetch_pend_i,
    input  logic                   adv_done_i,
    input  logic                   rd_done_i,
    input  logic [1:0]             rd_resp_i,
    input  logic [FRAME_W-1:0]     frame_num_i,
    input  logic [NPORT*CHG_W-1:0] port_chg_i,
    input  logic [NPORT-1:0]       port_owner_i,
    input  logic                   wake_i,
    input  logic [EVT_N-1:0]       irq_en_i,
    input  logic                   wr_en_i,
    input  logic [STAT_W-1:0]      wr_data_i,
    output logic [STAT_W-1:0]      status_o,
    output logic                   run_clear_o,
    output logic                   irq_o
);
    logic       halted;
    logic       mem_err;
    logic       flr_tog;
    logic       pcd_set;
    evt_t       set_ev;
    evt_t       flags;
    logic [EVT_N-1:0] clr_vec;
    logic [EVT_N-1:0] flag_vec;
    logic       run_clear_q;
    logic       irq_q;

    usbh_halt_trk halt_i (
        .clk      (clk),
        .rst      (rst),
        .run_i    (run_cmd_i),
        .idle_i   (engines_idle_i),
        .pend_i   (prefetch_pend_i),
        .halted_o (halted)
    );

    usbh_edge_det #(.W(1), .TOGGLE(1'b1)) roll_i (
        .clk   (clk),
        .rst   (rst),
        .lvl_i (frame_num_i[ROLL_BIT]),
        .evt_o (flr_tog)
    );

    usbh_port_agg #(.NPORT(NPORT)) ports_i (
        .clk       (clk),
        .rst       (rst),
        .chg_i     (port_chg_i),
        .owner_i   (port_owner_i),
        .wake_i    (wake_i),
        .pcd_set_o (pcd_set)
    );

    assign mem_err = rd_done_i && (rd_resp_i != RESP_OK);

    always_comb begin
        set_ev.aad = adv_done_i;
        set_ev.hse = mem_err;
        set_ev.flr = flr_tog;
        set_ev.pcd = pcd_set;
    end

    assign clr_vec = wr_en_i ? wr_data_i[EVT_LSB +: EVT_N] : '0;

    usbh_w1c_bank #(.N(EVT_N)) flags_i (
        .clk   (clk),
        .rst   (rst),
        .set_i (set_ev),
        .clr_i (clr_vec),
        .q_o   (flag_vec)
    );

    assign flags = evt_t'(flag_vec);

    always_ff @(posedge clk) begin
        if (rst) begin
            run_clear_q <= 1'b0;
            irq_q       <= 1'b0;
        end else begin
            run_clear_q <= mem_err;
            irq_q       <= |(flag_vec & irq_en_i);
        end
    end

    assign status_o    = pack_status(flags, halted);
    assign run_clear_o = run_clear_q;
    assign irq_o       = irq_q;
endmodule

// File: rtl/usbh_stat_chk.sv
module usbh_stat_chk (
    input logic        clk,
    input logic        rst,
    input logic        run_cmd_i,
    input logic        engines_idle_i,
    input logic        prefetch_pend_i,
    input logic        adv_done_i,
    input logic        rd_done_i,
    input logic [1:0]  rd_resp_i,
    input logic        frame13_i,
    input logic [3:0]  irq_en_i,
    input logic        wr_en_i,
    input logic [15:0] wr_data_i,
    input logic [15:0] status_o,
    input logic        run_clear_o,
    input logic        irq_o
);
    logic err_ev;
    assign err_ev = rd_done_i && (rd_resp_i != 2'b00);

    a_r1_halt_low_when_run: assert property (@(posedge clk) disable iff (rst)
        run_cmd_i |-> !status_o[12]);

    a_r2_halt_needs_quiet: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $rose(status_o[12])) |->
            $past(engines_idle_i && !prefetch_pend_i));

    a_r3_async_sets: assert property (@(posedge clk) disable iff (rst)
        adv_done_i |=> status_o[5]);

    a_r4_err_clears_run: assert property (@(posedge clk) disable iff (rst)
        err_ev |=> (run_clear_o && status_o[4]));

    a_r4_clear_has_cause: assert property (@(posedge clk) disable iff (rst)
        run_clear_o |-> $past(err_ev));

    a_r5_toggle_sets: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && (frame13_i != $past(frame13_i))) |=> status_o[3]);

    a_r8_w1c_clears: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && wr_data_i[4] && !err_ev) |=> !status_o[4]);

    a_r8_set_wins: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && wr_data_i[5] && adv_done_i) |=> status_o[5]);

    a_r9_irq_follows: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (irq_o == $past(|(status_o[5:2] & irq_en_i))));

    a_r10_reserved_zero: assert property (@(posedge clk) disable iff (rst)
        (status_o[15:13] == 3'b0) && (status_o[11:6] == 6'b0) &&
        (status_o[1:0] == 2'b0));
endmodule

bind usbh_stat_reg usbh_stat_chk chk_i (
    .clk             (clk),
    .rst             (rst),
    .run_cmd_i       (run_cmd_i),
    .engines_idle_i  (engines_idle_i),
    .prefetch_pend_i (prefetch_pend_i),
    .adv_done_i      (adv_done_i),
    .rd_done_i       (rd_done_i),
    .rd_resp_i       (rd_resp_i),
    .frame13_i       (frame_num_i[13]),
    .irq_en_i        (irq_en_i),
    .wr_en_i         (wr_en_i),
    .wr_data_i       (wr_data_i),
    .status_o        (status_o),
    .run_clear_o     (run_clear_o),
    .irq_o           (irq_o)
);

// File: tb/usbh_stat_reg_tb.sv
module usbh_stat_reg_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NPORT      = 4;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              run_cmd_i = 1'b0;
    logic              engines_idle_i = 1'b0;
    logic              prefetch_pend_i = 1'b0;
    logic              adv_done_i = 1'b0;
    logic              rd_done_i = 1'b0;
    logic [1:0]        rd_resp_i = 2'b00;
    logic [13:0]       frame_num_i = '0;
    logic [NPORT*4-1:0] port_chg_i = '0;
    logic [NPORT-1:0]  port_owner_i = '0;
    logic              wake_i = 1'b0;
    logic [3:0]        irq_en_i = '0;
    logic              wr_en_i = 1'b0;
    logic [15:0]       wr_data_i = '0;
    logic [15:0]       status_o;
    logic              run_clear_o;
    logic              irq_o;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    usbh_stat_reg #(.NPORT(NPORT), .FRAME_W(14)) dut_i (
        .clk             (clk),
        .rst             (rst),
        .run_cmd_i       (run_cmd_i),
        .engines_idle_i  (engines_idle_i),
        .prefetch_pend_i (prefetch_pend_i),
        .adv_done_i      (adv_done_i),
        .rd_done_i       (rd_done_i),
        .rd_resp_i       (rd_resp_i),
        .frame_num_i     (frame_num_i),
        .port_chg_i      (port_chg_i),
        .port_owner_i    (port_owner_i),
        .wake_i          (wake_i),
        .irq_en_i        (irq_en_i),
        .wr_en_i         (wr_en_i),
        .wr_data_i       (wr_data_i),
        .status_o        (status_o),
        .run_clear_o     (run_clear_o),
        .irq_o           (irq_o)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic w1c(input logic [15:0] d);
        wr_en_i   = 1'b1;
        wr_data_i = d;
        tick();
        wr_en_i   = 1'b0;
        wr_data_i = '0;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) tick();
        chk("R11 status in reset", status_o, 16'h1000);
        chk("R11 irq in reset", irq_o, 0);
        rst = 1'b0;
        #1;
        chk("R11 status after reset", status_o, 16'h1000);
        chk("R11 run_clear after reset", run_clear_o, 0);
        tick();
    endtask

    task automatic t_halt();
        run_cmd_i = 1'b1;
        #1;
        chk("R1 halted low with run", status_o[12], 0);
        engines_idle_i  = 1'b0;
        prefetch_pend_i = 1'b1;
        repeat (2) tick();
        chk("R1 halted still low", status_o[12], 0);
        run_cmd_i = 1'b0;
        repeat (2) tick();
        chk("R2 halted low while busy", status_o[12], 0);
        engines_idle_i = 1'b1;
        repeat (2) tick();
        chk("R2 halted low while prefetch pending", status_o[12], 0);
        prefetch_pend_i = 1'b0;
        tick();
        chk("R2 halted set when quiet", status_o[12], 1);
    endtask

    task automatic t_async();
        adv_done_i = 1'b1;
        tick();
        adv_done_i = 1'b0;
        chk("R3 async flag set", status_o[5], 1);
        chk("R9 irq off while disabled", irq_o, 0);
        chk("R10 reserved bits zero", status_o & 16'hEFC3, 0);
        irq_en_i = 4'b1000;
        tick();
        chk("R9 irq one clock after enable", irq_o, 1);
        w1c(16'h0000);
        chk("R8 zero write keeps flag", status_o[5], 1);
        w1c(16'h0020);
        chk("R8 one write clears flag", status_o[5], 0);
        chk("R9 irq lags clear by a clock", irq_o, 1);
        tick();
        chk("R9 irq drops", irq_o, 0);
        irq_en_i = 4'b0000;
    endtask

    task automatic t_hse();
        rd_done_i = 1'b1;
        rd_resp_i = 2'b00;
        tick();
        rd_done_i = 1'b0;
        chk("R4 success no flag", status_o[4], 0);
        chk("R4 success no run clear", run_clear_o, 0);
        rd_done_i = 1'b1;
        rd_resp_i = 2'b10;
        tick();
        rd_done_i = 1'b0;
        rd_resp_i = 2'b00;
        chk("R4 error flag", status_o[4], 1);
        chk("R4 run clear pulse", run_clear_o, 1);
        tick();
        chk("R4 run clear single cycle", run_clear_o, 0);
        chk("R4 error flag sticky", status_o[4], 1);
        w1c(16'h0010);
        chk("R8 error flag cleared", status_o[4], 0);
    endtask

    task automatic t_frame();
        frame_num_i = 14'h1FFF;
        repeat (2) tick();
        chk("R5 low bits ignored", status_o[3], 0);
        frame_num_i = 14'h2000;
        tick();
        chk("R5 bit13 rise sets rollover", status_o[3], 1);
        w1c(16'h0008);
        chk("R8 rollover cleared", status_o[3], 0);
        frame_num_i = 14'h2001;
        tick();
        chk("R5 no toggle no flag", status_o[3], 0);
        frame_num_i = 14'h0000;
        tick();
        chk("R5 bit13 fall sets rollover", status_o[3], 1);
        w1c(16'h0008);
        // set and clear in the same cycle
        frame_num_i = 14'h2000;
        wr_en_i     = 1'b1;
        wr_data_i   = 16'h0008;
        tick();
        wr_en_i   = 1'b0;
        wr_data_i = '0;
        chk("R8 set wins over clear", status_o[3], 1);
        w1c(16'h0008);
        chk("R8 rollover cleared again", status_o[3], 0);
    endtask

    task automatic t_port();
        port_owner_i = 4'b1100;
        port_chg_i[1*4+1] = 1'b1;
        tick();
        chk("R6 owned port enable change", status_o[2], 1);
        w1c(16'h0004);
        chk("R6 level held no new event", status_o[2], 0);
        port_chg_i[2*4+1] = 1'b1;
        repeat (2) tick();
        chk("R6 foreign enable change ignored", status_o[2], 0);
        port_chg_i[3*4+0] = 1'b1;
        tick();
        chk("R6 foreign connect change counts", status_o[2], 1);
        w1c(16'h0004);
    endtask

    task automatic t_wake();
        wake_i = 1'b1;
        tick();
        wake_i = 1'b0;
        chk("R7 wake loads OR of change bits", status_o[2], 1);
        w1c(16'h0004);
        port_chg_i = '0;
        tick();
        wake_i = 1'b1;
        tick();
        wake_i = 1'b0;
        chk("R7 wake with no change bits", status_o[2], 0);
    endtask

    initial begin
        t_reset();
        t_halt();
        t_async();
        t_hse();
        t_frame();
        t_port();
        t_wake();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures",
                 n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures",
                     n_checks, n_fails);
            $finish;
        end
    end
endmodule